// File: doc/BRIEF.md
# Interlace Field Parity Detector

This block decides whether the current field of a two-field interlaced video stream is odd or even. It looks at the line phase reported by an upstream horizontal timing generator. It samples that phase at the one clock in which the detected vertical sync signal falls. A phase close to the start of a line marks an odd field, and a phase close to the middle of a line marks an even field.

The decision is taken once per vertical interval and then held. Disturbances that come before or after that single sampling instant cannot change the result. These include stray equalizing pulses, jitter on the phase input, and a vertical sync level that stays low. A phase outside both tolerance bands leaves the previous decision in place and raises a single-cycle invalid strobe. A validity flag tells downstream logic when the parity output carries a real decision rather than its reset value.

The line-phase counter runs from 0 to LINE_LEN-1. The tolerance TOL is a parameter and defaults to one eighth of a line. With the defaults, LINE_LEN is 1716, so TOL is 214 and the mid-line point is 858.

Top module: `field_parity_detector`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with vsync_n high, odd_field, field_valid and phase_invalid are all 0.
- R2: A falling edge of vsync_n (high in the previous clock, low in this clock) sets odd_field to 1 from the next clock when line_phase is in the start band: either line_phase <= TOL, or LINE_LEN-TOL <= line_phase < LINE_LEN. With the defaults this means 0..214 or 1502..1715.
- R3: A falling edge of vsync_n clears odd_field to 0 from the next clock when line_phase is in the middle band, LINE_LEN/2-TOL <= line_phase <= LINE_LEN/2+TOL. With the defaults this means 644..1072.
- R4: A falling edge of vsync_n with line_phase in neither band leaves odd_field unchanged. This includes any value of LINE_LEN or above. In that case phase_invalid is 1 for exactly the next clock and then returns to 0.
- R5: field_valid becomes 1 on the first falling edge that yields an odd or even decision. It then stays 1 until reset. An invalid phase does not set it.
- R6: odd_field does not change in any cycle that does not follow a falling edge of vsync_n, whatever line_phase does meanwhile.
- R7: A vsync_n held low produces only one decision. A vsync_n that is already low when reset is released produces no decision until it has gone high and then fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_phase | input | PHASE_W | Current position within the line, 0..LINE_LEN-1 |
| vsync_n | input | 1 | Detected vertical sync, active low |
| odd_field | output | 1 | 1 for an odd field, 0 for an even field |
| field_valid | output | 1 | 1 once a field decision has been made |
| phase_invalid | output | 1 | One-cycle strobe: the phase at the sync edge was in neither band |

## Verification
Several rules are checked by the assertions on every cycle:
- the parity flag stays put unless a sync edge has just been seen;
- the flag is set or cleared as the band seen at the edge demands;
- the invalid strobe never lasts two cycles and never coincides with a change of parity;
- the validity flag never drops.

Other behaviour can only be shown by the bench's scenarios:
- the exact band boundaries on both sides of the line start and the mid-line point;
- the handling of out-of-range phase values;
- a first edge that is invalid and leaves the block unvalidated;
- a sync held low across reset release;
- phase jitter while sync holds either level.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ODD  = 2'd1,
        PH_EVEN = 2'd2
    } phase_class_t;

    typedef struct packed {
        logic odd;
        logic valid;
        logic bad;
    } flag_state_t;
endpackage

// File: rtl/fpd_edge.sv
module fpd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_n,
    output logic fall
);
    typedef struct packed {
        logic vs_prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.vs_prev = vsync_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall = st_q.vs_prev & ~vsync_n;

    // R7: an edge cannot be reported in two consecutive cycles
    p_single_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/fpd_classify.sv
module fpd_classify
    import fpd_pkg::*;
#(
    parameter int LINE_LEN = 1716,
    parameter int TOL      = LINE_LEN / 8,
    parameter int PHASE_W  = $clog2(LINE_LEN)
) (
    input  logic [PHASE_W-1:0] phase,
    output phase_class_t       cls
);
    localparam int EW = PHASE_W + 1;
    localparam logic [EW-1:0] C_TOL    = EW'(TOL);
    localparam logic [EW-1:0] C_LEN    = EW'(LINE_LEN);
    localparam logic [EW-1:0] C_TAIL   = EW'(LINE_LEN - TOL);
    localparam logic [EW-1:0] C_MID_LO = EW'(LINE_LEN / 2 - TOL);
    localparam logic [EW-1:0] C_MID_HI = EW'(LINE_LEN / 2 + TOL);

    logic [EW-1:0] p_ext;
    logic          near_start;
    logic          near_mid;

    always_comb begin
        p_ext      = {1'b0, phase};
        near_start = (p_ext <= C_TOL) || ((p_ext >= C_TAIL) && (p_ext < C_LEN));
        near_mid   = (p_ext >= C_MID_LO) && (p_ext <= C_MID_HI);
        if (near_start)    cls = PH_ODD;
        else if (near_mid) cls = PH_EVEN;
        else               cls = PH_NONE;
    end
endmodule

// File: rtl/fpd_flag.sv
module fpd_flag
    import fpd_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         decide,
    input  phase_class_t cls,
    output logic         odd_field,
    output logic         field_valid,
    output logic         phase_invalid
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (decide) begin
            case (cls)
                PH_ODD: begin
                    st_d.odd   = 1'b1;
                    st_d.valid = 1'b1;
                end
                PH_EVEN: begin
                    st_d.odd   = 1'b0;
                    st_d.valid = 1'b1;
                end
                default: st_d.bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign odd_field     = st_q.odd;
    assign field_valid   = st_q.valid;
    assign phase_invalid = st_q.bad;

    // R6: parity moves only after a sync edge
    p_hold_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !decide |=> $stable(odd_field));
    // R2: start-band edge yields odd
    p_odd_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && cls == PH_ODD) |=> (odd_field && field_valid));
    // R3: mid-band edge yields even
    p_even_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && cls == PH_EVEN) |=> (!odd_field && field_valid));
endmodule

// File: rtl/field_parity_detector.sv
module field_parity_detector
    import fpd_pkg::*;
#(
    parameter int LINE_LEN = 1716,
    parameter int TOL      = LINE_LEN / 8,
    parameter int PHASE_W  = $clog2(LINE_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] line_phase,
    input  logic               vsync_n,
    output logic               odd_field,
    output logic               field_valid,
    output logic               phase_invalid
);
    logic         fall;
    phase_class_t cls;

    fpd_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_n (vsync_n),
        .fall    (fall)
    );

    fpd_classify #(
        .LINE_LEN (LINE_LEN),
        .TOL      (TOL),
        .PHASE_W  (PHASE_W)
    ) u_cls (
        .phase (line_phase),
        .cls   (cls)
    );

    fpd_flag u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .decide        (fall),
        .cls           (cls),
        .odd_field     (odd_field),
        .field_valid   (field_valid),
        .phase_invalid (phase_invalid)
    );

    // R4: the invalid strobe lasts a single cycle
    p_invalid_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_invalid |=> !phase_invalid);
    // R4: an invalid phase leaves parity as it was
    p_invalid_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_invalid |-> $stable(odd_field));
    // R5: validity never drops outside reset
    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        field_valid |=> field_valid);
endmodule

// File: tb/sim_field_parity_detector.sv
module sim_field_parity_detector;
    localparam int LINE_LEN = 1716;
    localparam int TOL      = LINE_LEN / 8;
    localparam int HALF     = LINE_LEN / 2;
    localparam int PHASE_W  = $clog2(LINE_LEN);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [PHASE_W-1:0] line_phase = '0;
    logic               vsync_n = 1'b1;
    logic               odd_field, field_valid, phase_invalid;

    int checks = 0;
    int failures = 0;
    logic exp_odd = 1'b0;
    logic exp_valid = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    field_parity_detector #(.LINE_LEN(LINE_LEN), .TOL(TOL), .PHASE_W(PHASE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .line_phase(line_phase), .vsync_n(vsync_n),
        .odd_field(odd_field), .field_valid(field_valid), .phase_invalid(phase_invalid)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // kind: 0 start band, 1 middle band, 2 neither
    task automatic fire(input int p, input int kind, input string req);
        @(negedge clk);
        line_phase = PHASE_W'(p);
        vsync_n = 1'b0;
        @(negedge clk);
        if (kind == 0) begin exp_odd = 1'b1; exp_valid = 1'b1; end
        if (kind == 1) begin exp_odd = 1'b0; exp_valid = 1'b1; end
        check(req, $sformatf("odd_field phase=%0d", p), odd_field, exp_odd);
        check(req, $sformatf("field_valid phase=%0d", p), field_valid, exp_valid);
        check(req, $sformatf("phase_invalid phase=%0d", p), phase_invalid, kind == 2);
        @(negedge clk);
        check(req, "phase_invalid drops after one cycle", phase_invalid, 1'b0);
        vsync_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_low();
        rst_n = 1'b0;
        vsync_n = 1'b0;
        exp_odd = 1'b0;
        exp_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "odd_field in reset", odd_field, 1'b0);
        check("R1", "field_valid in reset", field_valid, 1'b0);
        check("R1", "phase_invalid in reset", phase_invalid, 1'b0);
        rst_n = 1'b1;
        line_phase = PHASE_W'(400);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7", "no decision while low after reset", phase_invalid | field_valid, 1'b0);
        end
        vsync_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_idle();
        rst_n = 1'b0;
        vsync_n = 1'b1;
        exp_odd = 1'b0;
        exp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "odd_field after release", odd_field, 1'b0);
        check("R1", "field_valid after release", field_valid, 1'b0);
        check("R1", "phase_invalid after release", phase_invalid, 1'b0);
    endtask

    task automatic t_first_invalid();
        fire(400, 2, "R5");
        check("R5", "invalid first edge leaves unvalidated", field_valid, 1'b0);
    endtask

    task automatic t_odd_even();
        fire(0, 0, "R2");
        fire(HALF, 1, "R3");
        fire(LINE_LEN - 10, 0, "R2");
        fire(HALF + 100, 1, "R3");
    endtask

    task automatic t_boundaries();
        fire(TOL, 0, "R2");
        fire(HALF - TOL, 1, "R3");
        fire(LINE_LEN - TOL, 0, "R2");
        fire(HALF + TOL, 1, "R3");
        fire(TOL + 1, 2, "R4");
        fire(LINE_LEN - TOL - 1, 2, "R4");
        fire(0, 0, "R2");
        fire(HALF - TOL - 1, 2, "R4");
        fire(HALF + TOL + 1, 2, "R4");
        fire(1800, 2, "R4");
        fire(LINE_LEN, 2, "R4");
    endtask

    task automatic t_hold_low();
        fire(HALF, 1, "R3");
        @(negedge clk);
        vsync_n = 1'b0;
        line_phase = '0;
        @(negedge clk);
        check("R7", "decision on held-low edge", odd_field, 1'b1);
        exp_odd = 1'b1;
        for (int i = 0; i < 12; i++) begin
            line_phase = PHASE_W'((i * 97) % LINE_LEN);
            @(negedge clk);
            check("R7", "odd_field while held low", odd_field, exp_odd);
            check("R7", "no strobe while held low", phase_invalid, 1'b0);
        end
        vsync_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_phase_noise();
        for (int i = 0; i < 20; i++) begin
            line_phase = PHASE_W'(HALF + ((i % 2) == 0 ? i : -i));
            @(negedge clk);
            check("R6", "odd_field with sync idle", odd_field, exp_odd);
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_low();
        t_reset_idle();
        t_first_invalid();
        t_odd_even();
        t_boundaries();
        t_hold_low();
        t_phase_noise();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule